// File: doc/BRIEF.md
# Retrace-Clocked CRT Timing Generator

This block is the timing core of a character-based CRT controller. A horizontal character counter runs from zero to a programmable total. Comparisons against programmable limits for display end, blanking and retrace produce horizontal sync, horizontal blanking and a display-enable window. That window can be shifted right by a small programmable skew.

The vertical side is not clocked by the wrap of the horizontal counter. The line counter, the row-scan counter inside a character cell and the character-row counter all step on the rising edge of horizontal sync. A control bit can halve that rate, so the vertical side steps on every second sync pulse instead. The character clocks that follow the end of retrace, up to the horizontal total, therefore already belong to the next internal line. Their vertical blanking follows that line's state.

At vertical total a new frame begins:
- the line counter returns to zero;
- the row-scan counter loads a preset value;
- the character row clears;
- the start address is captured.

All timing values are plain input ports that an outside register file drives.

Top module: `crt_timing_core`

## Requirements
- R1: `hcount` increments by one on every clock. In the clock after it equals `h_total`, it becomes 0.
- R2: `hsync` becomes 1 in the clock after `hcount` equals `h_sync_start`. It becomes 0 in the clock after the low 5 bits of `hcount` equal `h_sync_end`. The start match wins over the end match.
- R3: `line_count` changes only at the clock edge where `hsync` goes from 0 to 1, and it does so in that same edge. Wrapping of `hcount` alone never changes `line_count`, so a sync start value above `h_total` freezes the vertical side.
- R4: With `vclk_half` at 0, every rising edge of `hsync` is a vertical step. With `vclk_half` at 1, only every second rising edge is a step, counted from a phase that clears on reset and at vertical total. The first rising edge after a clear is skipped.
- R5: On a vertical step that is not a frame wrap, `row_scan` increments. If `row_scan` equals `row_max`, it becomes 0 instead and `char_row` increments.
- R6: On a vertical step taken while `line_count` equals `v_total`, all of the following happen at once: `line_count` becomes 0, `row_scan` loads `row_preset`, `char_row` becomes 0 and `frame_addr` captures `start_addr`. At no other time does `frame_addr` change.
- R7: Horizontal blanking becomes 1 in the clock after `hcount` equals `h_blank_start`. It becomes 0 in the clock after the low 6 bits of `hcount` equal `h_blank_end`. The start match wins. `blank` is horizontal blanking OR vertical blanking.
- R8: `vsync` becomes 1 in the clock after `line_count` equals `v_sync_start`. It becomes 0 in the clock after the low 4 bits of `line_count` equal `v_sync_end`. Vertical blanking behaves the same way, using `v_blank_start` and the low 8 bits against `v_blank_end`. In both cases the start match wins.
- R9: `disp_en` is 1 only when all three of these hold: (`hcount` < `h_disp_end`) taken `disp_skew` clocks earlier (0 to 3), `line_count` < `v_disp_end`, and vertical blanking is 0.
- R10: While `rst` is 1, every counter, `frame_addr`, `hsync`, `vsync`, `blank` and the skew pipeline clear to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | 8 | Last value of the horizontal counter |
| h_disp_end | input | 8 | Horizontal count where active display stops |
| h_blank_start | input | 8 | Horizontal count that starts blanking |
| h_blank_end | input | 6 | Low-bit count that ends blanking |
| h_sync_start | input | 8 | Horizontal count that raises hsync |
| h_sync_end | input | 5 | Low-bit count that drops hsync |
| disp_skew | input | 2 | Display-enable delay in character clocks |
| v_total | input | 10 | Last line of the frame |
| v_disp_end | input | 10 | Line where active display stops |
| v_blank_start | input | 10 | Line that starts vertical blanking |
| v_blank_end | input | 8 | Low-bit line that ends vertical blanking |
| v_sync_start | input | 10 | Line that raises vsync |
| v_sync_end | input | 4 | Low-bit line that drops vsync |
| vclk_half | input | 1 | Step vertical side on every second hsync |
| row_max | input | 5 | Last row-scan value of a character cell |
| row_preset | input | 5 | Row-scan value loaded at frame start |
| start_addr | input | 16 | Start address captured at vertical total |
| hcount | output | 8 | Horizontal character counter |
| line_count | output | 10 | Vertical line counter |
| row_scan | output | 5 | Row-scan counter within a character cell |
| char_row | output | 8 | Character-row counter |
| frame_addr | output | 16 | Start address latched for the current frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Horizontal or vertical blanking |
| disp_en | output | 1 | Active display window |

## Verification
The bench builds the core with its default parameters:
- an 8-bit horizontal counter;
- a 10-bit line counter;
- a skew pipeline three stages deep.

With these, every skew setting can be reached. A programmed line length of twenty clocks keeps whole frames short. Because that total sits below 32, sync and blank end values that lie past the total wrap onto the following line through the 5- and 6-bit compares. A sync start placed beyond the total leaves the vertical side frozen. A start address changed mid-frame shows that capture happens only at vertical total.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int HC_W_DEF  = 8;
    localparam int LC_W_DEF  = 10;
    localparam int RS_W_DEF  = 5;
    localparam int CR_W_DEF  = 8;
    localparam int AD_W_DEF  = 16;
    localparam int SKEW_DEF  = 3;
    localparam int HSE_W_DEF = 5;
    localparam int HBE_W_DEF = 6;
    localparam int VSE_W_DEF = 4;
    localparam int VBE_W_DEF = 8;

    // Horizontal flag pair held in one register.
    typedef struct packed {
        logic sync;
        logic blank;
    } hflags_t;

    // Vertical flag pair held in one register.
    typedef struct packed {
        logic sync;
        logic blank;
    } vflags_t;

    // What the vertical side does on a given clock.
    typedef enum logic [1:0] {
        VACT_HOLD = 2'd0,
        VACT_STEP = 2'd1,
        VACT_WRAP = 2'd2
    } vact_e;

    // Compare only the low n bits of two values.
    function automatic logic low_bits_eq(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int n);
        logic [31:0] mask;
        mask = (32'h1 << n) - 32'h1;
        return ((a ^ b) & mask) == 32'h0;
    endfunction

    // Set-priority flag update: a start match sets, an end match clears.
    function automatic logic flag_next(input logic cur,
                                       input logic hit_start,
                                       input logic hit_end);
        if (hit_start)    return 1'b1;
        else if (hit_end) return 1'b0;
        else              return cur;
    endfunction

endpackage

// File: rtl/crt_hgen.sv
module crt_hgen
    import crt_pkg::*;
#(
    parameter int HC_W     = HC_W_DEF,
    parameter int HSE_W    = HSE_W_DEF,
    parameter int HBE_W    = HBE_W_DEF,
    parameter int SKEW_MAX = SKEW_DEF,
    parameter int SKEW_W   = $clog2(SKEW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HC_W-1:0]   h_total,
    input  logic [HC_W-1:0]   h_disp_end,
    input  logic [HC_W-1:0]   h_blank_start,
    input  logic [HBE_W-1:0]  h_blank_end,
    input  logic [HC_W-1:0]   h_sync_start,
    input  logic [HSE_W-1:0]  h_sync_end,
    input  logic [SKEW_W-1:0] skew,
    output logic [HC_W-1:0]   hcount,
    output logic              hsync,
    output logic              hblank,
    output logic              hde,
    output logic              retrace_tick
);

    hflags_t           flags_q;
    logic              hit_total;
    logic              hit_ss;
    logic              hit_se;
    logic              hit_bs;
    logic              hit_be;
    logic [SKEW_MAX:0] de_pipe;

    assign hit_total = (hcount == h_total);
    assign hit_ss    = (hcount == h_sync_start);
    assign hit_bs    = (hcount == h_blank_start);
    assign hit_se    = low_bits_eq(32'(hcount), 32'(h_sync_end), HSE_W);
    assign hit_be    = low_bits_eq(32'(hcount), 32'(h_blank_end), HBE_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcount  <= '0;
            flags_q <= '0;
        end else begin
            hcount        <= hit_total ? '0 : hcount + 1'b1;
            flags_q.sync  <= flag_next(flags_q.sync, hit_ss, hit_se);
            flags_q.blank <= flag_next(flags_q.blank, hit_bs, hit_be);
        end
    end

    assign hsync  = flags_q.sync;
    assign hblank = flags_q.blank;

    // A 0-to-1 step of hsync happens at the coming edge.
    assign retrace_tick = !rst && hit_ss && !flags_q.sync;

    // Skew pipeline for the display window.
    assign de_pipe[0] = (hcount < h_disp_end);

    generate
        for (genvar k = 1; k <= SKEW_MAX; k++) begin : g_skew
            always_ff @(posedge clk) begin
                if (rst) de_pipe[k] <= 1'b0;
                else     de_pipe[k] <= de_pipe[k-1];
            end
        end
    endgenerate

    always_comb begin
        hde = 1'b0;
        for (int i = 0; i <= SKEW_MAX; i++) begin
            if (32'(skew) == i) hde = de_pipe[i];
        end
    end

    // R1
    hcount_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hcount != '0) |-> (hcount == HC_W'($past(hcount) + 1'b1)));

    // R2
    hsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> ($past(hcount) == $past(h_sync_start)));

endmodule

// File: rtl/crt_vgen.sv
module crt_vgen
    import crt_pkg::*;
#(
    parameter int LC_W  = LC_W_DEF,
    parameter int RS_W  = RS_W_DEF,
    parameter int CR_W  = CR_W_DEF,
    parameter int AD_W  = AD_W_DEF,
    parameter int VSE_W = VSE_W_DEF,
    parameter int VBE_W = VBE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [LC_W-1:0]   v_total,
    input  logic [LC_W-1:0]   v_disp_end,
    input  logic [LC_W-1:0]   v_blank_start,
    input  logic [VBE_W-1:0]  v_blank_end,
    input  logic [LC_W-1:0]   v_sync_start,
    input  logic [VSE_W-1:0]  v_sync_end,
    input  logic              half_rate,
    input  logic [RS_W-1:0]   row_max,
    input  logic [RS_W-1:0]   row_preset,
    input  logic [AD_W-1:0]   start_addr,
    output logic [LC_W-1:0]   line_cnt,
    output logic [RS_W-1:0]   row_scan,
    output logic [CR_W-1:0]   char_row,
    output logic [AD_W-1:0]   frame_addr,
    output logic              vsync,
    output logic              vblank,
    output logic              vde,
    output logic              adv
);

    vflags_t flags_q;
    logic    phase_q;
    vact_e   act;

    assign adv = tick && (!half_rate || phase_q);

    always_comb begin
        if (!adv)                      act = VACT_HOLD;
        else if (line_cnt == v_total)  act = VACT_WRAP;
        else                           act = VACT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt   <= '0;
            row_scan   <= '0;
            char_row   <= '0;
            frame_addr <= '0;
            phase_q    <= 1'b0;
        end else begin
            unique case (act)
                VACT_WRAP: begin
                    line_cnt   <= '0;
                    row_scan   <= row_preset;
                    char_row   <= '0;
                    frame_addr <= start_addr;
                    phase_q    <= 1'b0;
                end
                VACT_STEP: begin
                    line_cnt <= line_cnt + 1'b1;
                    phase_q  <= !phase_q;
                    if (row_scan == row_max) begin
                        row_scan <= '0;
                        char_row <= char_row + 1'b1;
                    end else begin
                        row_scan <= row_scan + 1'b1;
                    end
                end
                default: begin
                    if (tick) phase_q <= !phase_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.sync  <= flag_next(flags_q.sync,
                                       line_cnt == v_sync_start,
                                       low_bits_eq(32'(line_cnt), 32'(v_sync_end), VSE_W));
            flags_q.blank <= flag_next(flags_q.blank,
                                       line_cnt == v_blank_start,
                                       low_bits_eq(32'(line_cnt), 32'(v_blank_end), VBE_W));
        end
    end

    assign vsync  = flags_q.sync;
    assign vblank = flags_q.blank;
    assign vde    = (line_cnt < v_disp_end);

    // R6
    frame_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(adv) && ($past(line_cnt) == $past(v_total)))
        |-> (row_scan == $past(row_preset)) && (frame_addr == $past(start_addr)));

    // R5
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(adv) && ($past(row_scan) == $past(row_max)) && ($past(line_cnt) != $past(v_total)))
        |-> (row_scan == '0));

    // R8
    vsync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |-> ($past(line_cnt[VSE_W-1:0]) == $past(v_sync_end)));

endmodule

// File: rtl/crt_timing_core.sv
module crt_timing_core
    import crt_pkg::*;
#(
    parameter int HC_W     = HC_W_DEF,
    parameter int LC_W     = LC_W_DEF,
    parameter int RS_W     = RS_W_DEF,
    parameter int CR_W     = CR_W_DEF,
    parameter int AD_W     = AD_W_DEF,
    parameter int SKEW_MAX = SKEW_DEF,
    parameter int HSE_W    = HSE_W_DEF,
    parameter int HBE_W    = HBE_W_DEF,
    parameter int VSE_W    = VSE_W_DEF,
    parameter int VBE_W    = VBE_W_DEF,
    localparam int SKEW_W  = $clog2(SKEW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HC_W-1:0]   h_total,
    input  logic [HC_W-1:0]   h_disp_end,
    input  logic [HC_W-1:0]   h_blank_start,
    input  logic [HBE_W-1:0]  h_blank_end,
    input  logic [HC_W-1:0]   h_sync_start,
    input  logic [HSE_W-1:0]  h_sync_end,
    input  logic [SKEW_W-1:0] disp_skew,
    input  logic [LC_W-1:0]   v_total,
    input  logic [LC_W-1:0]   v_disp_end,
    input  logic [LC_W-1:0]   v_blank_start,
    input  logic [VBE_W-1:0]  v_blank_end,
    input  logic [LC_W-1:0]   v_sync_start,
    input  logic [VSE_W-1:0]  v_sync_end,
    input  logic              vclk_half,
    input  logic [RS_W-1:0]   row_max,
    input  logic [RS_W-1:0]   row_preset,
    input  logic [AD_W-1:0]   start_addr,
    output logic [HC_W-1:0]   hcount,
    output logic [LC_W-1:0]   line_count,
    output logic [RS_W-1:0]   row_scan,
    output logic [CR_W-1:0]   char_row,
    output logic [AD_W-1:0]   frame_addr,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              disp_en
);

    logic hblank;
    logic hde;
    logic tick;
    logic vblank;
    logic vde;
    logic adv;

    crt_hgen #(
        .HC_W(HC_W), .HSE_W(HSE_W), .HBE_W(HBE_W),
        .SKEW_MAX(SKEW_MAX), .SKEW_W(SKEW_W)
    ) u_h (
        .clk(clk), .rst(rst),
        .h_total(h_total), .h_disp_end(h_disp_end),
        .h_blank_start(h_blank_start), .h_blank_end(h_blank_end),
        .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
        .skew(disp_skew),
        .hcount(hcount), .hsync(hsync), .hblank(hblank),
        .hde(hde), .retrace_tick(tick)
    );

    crt_vgen #(
        .LC_W(LC_W), .RS_W(RS_W), .CR_W(CR_W), .AD_W(AD_W),
        .VSE_W(VSE_W), .VBE_W(VBE_W)
    ) u_v (
        .clk(clk), .rst(rst), .tick(tick),
        .v_total(v_total), .v_disp_end(v_disp_end),
        .v_blank_start(v_blank_start), .v_blank_end(v_blank_end),
        .v_sync_start(v_sync_start), .v_sync_end(v_sync_end),
        .half_rate(vclk_half), .row_max(row_max), .row_preset(row_preset),
        .start_addr(start_addr),
        .line_cnt(line_count), .row_scan(row_scan), .char_row(char_row),
        .frame_addr(frame_addr), .vsync(vsync), .vblank(vblank),
        .vde(vde), .adv(adv)
    );

    assign blank   = hblank | vblank;
    assign disp_en = hde & vde & ~vblank;

    // R3
    line_on_retrace_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_count) |-> $past(adv));

    // R3
    line_with_hsync_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_count) |-> $rose(hsync));

    // R9
    de_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> !vblank);

endmodule

// File: tb/tb_crt_timing_core.sv
`timescale 1ns/1ps
module tb_crt_timing_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  h_total, h_disp_end, h_blank_start, h_sync_start;
    logic [5:0]  h_blank_end;
    logic [4:0]  h_sync_end;
    logic [1:0]  disp_skew;
    logic [9:0]  v_total, v_disp_end, v_blank_start, v_sync_start;
    logic [7:0]  v_blank_end;
    logic [3:0]  v_sync_end;
    logic        vclk_half;
    logic [4:0]  row_max, row_preset;
    logic [15:0] start_addr;
    logic [7:0]  hcount;
    logic [9:0]  line_count;
    logic [4:0]  row_scan;
    logic [7:0]  char_row;
    logic [15:0] frame_addr;
    logic        hsync, vsync, blank, disp_en;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    crt_timing_core dut (
        .clk(clk), .rst(rst),
        .h_total(h_total), .h_disp_end(h_disp_end),
        .h_blank_start(h_blank_start), .h_blank_end(h_blank_end),
        .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
        .disp_skew(disp_skew),
        .v_total(v_total), .v_disp_end(v_disp_end),
        .v_blank_start(v_blank_start), .v_blank_end(v_blank_end),
        .v_sync_start(v_sync_start), .v_sync_end(v_sync_end),
        .vclk_half(vclk_half), .row_max(row_max), .row_preset(row_preset),
        .start_addr(start_addr),
        .hcount(hcount), .line_count(line_count), .row_scan(row_scan),
        .char_row(char_row), .frame_addr(frame_addr),
        .hsync(hsync), .vsync(vsync), .blank(blank), .disp_en(disp_en)
    );

    // Behavioural reference state
    int m_h, m_line, m_row, m_crow, m_addr;
    bit m_hs, m_hb, m_vs, m_vb, m_ph;
    bit m_de[1:3];

    always @(posedge clk) begin
        bit tick, step;
        if (rst) begin
            m_h = 0; m_line = 0; m_row = 0; m_crow = 0; m_addr = 0;
            m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0; m_ph = 0;
            m_de[1] = 0; m_de[2] = 0; m_de[3] = 0;
        end else begin
            tick = (m_h == int'(h_sync_start)) && !m_hs;
            step = tick && (!vclk_half || m_ph);
            m_de[3] = m_de[2];
            m_de[2] = m_de[1];
            m_de[1] = (m_h < int'(h_disp_end));
            if (m_line == int'(v_sync_start))              m_vs = 1;
            else if ((m_line % 16) == int'(v_sync_end))    m_vs = 0;
            if (m_line == int'(v_blank_start))             m_vb = 1;
            else if ((m_line % 256) == int'(v_blank_end))  m_vb = 0;
            if (m_h == int'(h_sync_start))                 m_hs = 1;
            else if ((m_h % 32) == int'(h_sync_end))       m_hs = 0;
            if (m_h == int'(h_blank_start))                m_hb = 1;
            else if ((m_h % 64) == int'(h_blank_end))      m_hb = 0;
            if (step && m_line == int'(v_total)) begin
                m_line = 0; m_row = int'(row_preset); m_crow = 0;
                m_addr = int'(start_addr); m_ph = 0;
            end else begin
                if (step) begin
                    m_line = (m_line + 1) % 1024;
                    if (m_row == int'(row_max)) begin
                        m_row = 0; m_crow = (m_crow + 1) % 256;
                    end else begin
                        m_row = (m_row + 1) % 32;
                    end
                end
                if (tick) m_ph = !m_ph;
            end
            m_h = (m_h == int'(h_total)) ? 0 : (m_h + 1) % 256;
        end
    end

    task automatic chk(input string req, input string nm, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit de0, dsk;
        de0 = (m_h < int'(h_disp_end));
        case (disp_skew)
            2'd0: dsk = de0;
            2'd1: dsk = m_de[1];
            2'd2: dsk = m_de[2];
            default: dsk = m_de[3];
        endcase
        if (rst) begin
            // R10 reset state
            chk("R10", "hcount", int'(hcount), 0);
            chk("R10", "line", int'(line_count), 0);
            chk("R10", "row", int'(row_scan), 0);
            chk("R10", "frame_addr", int'(frame_addr), 0);
            chk("R10", "sync", int'({hsync, vsync, blank}), 0);
        end else begin
            chk("R1", "hcount", int'(hcount), m_h);
            chk("R2", "hsync", int'(hsync), int'(m_hs));
            chk("R3_R4", "line_count", int'(line_count), m_line);
            chk("R5", "row_scan", int'(row_scan), m_row);
            chk("R5", "char_row", int'(char_row), m_crow);
            chk("R6", "frame_addr", int'(frame_addr), m_addr);
            chk("R7", "blank", int'(blank), int'(m_hb | m_vb));
            chk("R8", "vsync", int'(vsync), int'(m_vs));
            chk("R9", "disp_en", int'(disp_en),
                int'(dsk && (m_line < int'(v_disp_end)) && !m_vb));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(3);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        // Scenario A: full rate, no skew, ends before total
        h_total = 8'd19; h_disp_end = 8'd12; h_blank_start = 8'd13; h_blank_end = 6'd18;
        h_sync_start = 8'd14; h_sync_end = 5'd17; disp_skew = 2'd0;
        v_total = 10'd9; v_disp_end = 10'd6; v_blank_start = 10'd7; v_blank_end = 8'd9;
        v_sync_start = 10'd7; v_sync_end = 4'd8; vclk_half = 1'b0;
        row_max = 5'd2; row_preset = 5'd1; start_addr = 16'h1234;
        do_reset();
        run(640);
        // R6: start address changed mid-frame, captured only at wrap
        start_addr = 16'h0A5A;
        run(420);

        // Scenario B: half-rate vertical clock, skew 2, ends wrap past total
        h_blank_start = 8'd15; h_blank_end = 6'd2; h_sync_start = 8'd16; h_sync_end = 5'd1;
        disp_skew = 2'd2; vclk_half = 1'b1; row_max = 5'd3; row_preset = 5'd0;
        start_addr = 16'hBEEF; v_blank_end = 8'd0; v_sync_end = 4'd9;
        do_reset();
        run(900);

        // Scenario C: skew 3, skew 1, preset above max
        disp_skew = 2'd3; vclk_half = 1'b0; row_preset = 5'd4; row_max = 5'd1;
        do_reset();
        run(450);
        disp_skew = 2'd1;
        run(300);

        // Scenario D: R3 sync start beyond total, vertical side frozen
        h_sync_start = 8'd25;
        do_reset();
        run(200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule